// File: doc/BRIEF.md
# Rectification Map Stream Decompressor

This block turns a compressed stream of lens-correction map bytes back into per-pixel source coordinates. One byte arrives per output pixel, in raster order, over a valid/ready stream whose user bit marks the first pixel of a frame. At every position only one of the two offset components (horizontal or vertical) is carried, and the two components swap places on a checkerboard. The block rebuilds the carried component from a short delta chain within the row. It estimates the other component from the value one column to the left and the value in the same column of the row above, which it keeps in a one-row line buffer.

For each accepted byte the block emits one result beat. The beat holds the absolute source coordinate, which is the pixel's own column and row plus the rebuilt offsets. Each axis is split into a signed whole-pixel part and a 7-bit fraction, ready for an address generator and a bilinear sampler further down the chain. The output is registered, and the block stalls its input while a result waits to be taken.

Top module: `map_stream_decomp`

## Requirements
- R1: After reset `m_valid` is 0 and `s_ready` is 1.
- R2: In columns 0 and 1 of a row the byte is a two's-complement whole-pixel offset, so byte b gives an offset of b pixels with a zero fraction.
- R3: From column 2 onward the byte is a two's-complement delta in units of 1/128 pixel. It is added to the rebuilt value of the same component two columns to the left, in the same row, without wrapping for offsets up to ±1280 pixels.
- R4: When column plus row is even the byte carries the horizontal (x) component. When it is odd the byte carries the vertical (y) component.
- R5: The component not carried at a position equals floor((A + L) / 2). A is the carried value in the same column of the previous row, and L is the carried value in the previous column of the current row.
- R6: In row 0 the missing component equals L. In column 0 of later rows it equals A. At row 0, column 0 it is zero.
- R7: The output coordinates are x = column·128 + x offset and y = row·128 + y offset, in 1/128-pixel units. The integer field is the floor of the coordinate divided by 128, and the fraction field holds its low 7 bits.
- R8: A beat with `s_sof` high is treated as row 0, column 0, whatever came before, and its result carries `m_sof` high. `m_last` is high on the result for the last column of each row.
- R9: While `m_valid` is high and `m_ready` is low, every output holds its value. A byte taken by the handshake yields a result with `m_valid` high on the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| s_valid | input | 1 | Compressed byte valid |
| s_ready | output | 1 | Block can take a byte |
| s_data | input | 8 | Compressed map byte |
| s_sof | input | 1 | First byte of a frame |
| m_valid | output | 1 | Result valid |
| m_ready | input | 1 | Downstream takes the result |
| m_sof | output | 1 | Result is row 0, column 0 |
| m_last | output | 1 | Result is the last column of its row |
| m_x_int | output | COORD_INT_W | Signed whole-pixel source column |
| m_x_frac | output | 7 | Source column fraction, 1/128 units |
| m_y_int | output | COORD_INT_W | Signed whole-pixel source row |
| m_y_frac | output | 7 | Source row fraction, 1/128 units |

## Verification
Frames built from random smooth offset fields are compressed by a model in the bench. This exercises the checkerboard swap, so a design that decodes the component parity from the column alone would put x and y into the wrong fields on odd rows. Frames made entirely of +127 and −128 deltas drive the delta chain toward its extremes. These frames expose a design that adds the delta to the neighbouring column, or one that wraps or truncates the running value. The edge positions are row 0, column 0 and the first two columns, where a missing neighbour or a leftover neighbour from the previous row would show up as a wrong estimate or a stray fraction. A frame that is cut off and restarted by a start-of-frame beat tests that the counters really restart. Random output back-pressure tests that nothing is lost or changed during a stall.

// File: rtl/mapdec_pkg.sv
package mapdec_pkg;

    localparam int FRAC_W    = 7;
    localparam int OFS_INT_W = 11;
    localparam int ACC_W     = OFS_INT_W + FRAC_W + 1;

    typedef logic signed [ACC_W-1:0] acc_t;

    typedef struct packed {
        acc_t x;
        acc_t y;
    } ofs_pair_t;

    // whole-pixel code: signed pixels, scaled to 1/128 units
    function automatic acc_t whole_from_code(input logic [7:0] code);
        acc_t v;
        v = acc_t'($signed(code));
        return v <<< FRAC_W;
    endfunction

    // delta code: signed, already in 1/128 units
    function automatic acc_t delta_from_code(input logic [7:0] code);
        return acc_t'($signed(code));
    endfunction

    // floor of the mean of two values
    function automatic acc_t mean_floor(input acc_t a, input acc_t b);
        logic signed [ACC_W:0] s;
        s = {a[ACC_W-1], a} + {b[ACC_W-1], b};
        return s[ACC_W:1];
    endfunction

endpackage

// File: rtl/mapdec_pos.sv
module mapdec_pos #(
    parameter int IMG_W = 1280,
    parameter int IMG_H = 960,
    localparam int COL_W = $clog2(IMG_W),
    localparam int ROW_W = $clog2(IMG_H)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             advance,
    input  logic             sof,
    output logic [COL_W-1:0] col,
    output logic [ROW_W-1:0] row
);
    logic [COL_W-1:0] col_q;
    logic [ROW_W-1:0] row_q;

    // a start-of-frame beat is always position (0,0)
    assign col = sof ? '0 : col_q;
    assign row = sof ? '0 : row_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            col_q <= '0;
            row_q <= '0;
        end else if (advance) begin
            if (col == COL_W'(IMG_W - 1)) begin
                col_q <= '0;
                row_q <= (row == ROW_W'(IMG_H - 1)) ? '0 : row + 1'b1;
            end else begin
                col_q <= col + 1'b1;
                row_q <= row;
            end
        end
    end
endmodule

// File: rtl/mapdec_linebuf.sv
module mapdec_linebuf #(
    parameter int DEPTH = 1280,
    parameter int DW    = 19,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic [AW-1:0] addr,
    input  logic          we,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] mem [DEPTH];

    // read returns the previous row's entry; write replaces it afterwards
    assign rdata = mem[addr];

    always_ff @(posedge clk) begin
        if (we) mem[addr] <= wdata;
    end
endmodule

// File: rtl/mapdec_recon.sv
module mapdec_recon
    import mapdec_pkg::*;
#(
    parameter int COL_W = 11,
    parameter int ROW_W = 10
) (
    input  logic [7:0]       code,
    input  logic [COL_W-1:0] col,
    input  logic [ROW_W-1:0] row,
    input  acc_t             left1,
    input  acc_t             left2,
    input  acc_t             above,
    output acc_t             kept,
    output ofs_pair_t        ofs
);
    logic x_carried;
    acc_t missing;

    assign x_carried = ~(col[0] ^ row[0]);

    always_comb begin
        if (col < COL_W'(2)) kept = whole_from_code(code);
        else                 kept = left2 + delta_from_code(code);

        unique case ({row != '0, col != '0})
            2'b11:   missing = mean_floor(above, left1);
            2'b01:   missing = left1;
            2'b10:   missing = above;
            default: missing = '0;
        endcase

        ofs.x = x_carried ? kept : missing;
        ofs.y = x_carried ? missing : kept;
    end
endmodule

// File: rtl/map_stream_decomp.sv
module map_stream_decomp
    import mapdec_pkg::*;
#(
    parameter int IMG_W       = 1280,
    parameter int IMG_H       = 960,
    parameter int COORD_INT_W = 13
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   s_valid,
    output logic                   s_ready,
    input  logic [7:0]             s_data,
    input  logic                   s_sof,
    output logic                   m_valid,
    input  logic                   m_ready,
    output logic                   m_sof,
    output logic                   m_last,
    output logic [COORD_INT_W-1:0] m_x_int,
    output logic [FRAC_W-1:0]      m_x_frac,
    output logic [COORD_INT_W-1:0] m_y_int,
    output logic [FRAC_W-1:0]      m_y_frac
);
    localparam int COL_W = $clog2(IMG_W);
    localparam int ROW_W = $clog2(IMG_H);
    localparam int ABS_W = COORD_INT_W + FRAC_W;

    logic             take;
    logic [COL_W-1:0] col;
    logic [ROW_W-1:0] row;
    acc_t             left1_q, left2_q, above, kept;
    ofs_pair_t        ofs;
    logic signed [ABS_W-1:0] ax, ay, ax_q, ay_q;

    assign s_ready = ~m_valid | m_ready;
    assign take    = s_valid & s_ready;

    mapdec_pos #(.IMG_W(IMG_W), .IMG_H(IMG_H)) u_pos (
        .clk(clk), .rst(rst), .advance(take), .sof(s_sof),
        .col(col), .row(row)
    );

    mapdec_linebuf #(.DEPTH(IMG_W), .DW(ACC_W)) u_lbuf (
        .clk(clk), .addr(col), .we(take), .wdata(kept), .rdata(above)
    );

    mapdec_recon #(.COL_W(COL_W), .ROW_W(ROW_W)) u_recon (
        .code(s_data), .col(col), .row(row),
        .left1(left1_q), .left2(left2_q), .above(above),
        .kept(kept), .ofs(ofs)
    );

    always_comb begin
        ax = (ABS_W'(col) <<< FRAC_W) + ABS_W'(ofs.x);
        ay = (ABS_W'(row) <<< FRAC_W) + ABS_W'(ofs.y);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            m_valid <= 1'b0;
            m_sof   <= 1'b0;
            m_last  <= 1'b0;
            ax_q    <= '0;
            ay_q    <= '0;
            left1_q <= '0;
            left2_q <= '0;
        end else if (take) begin
            m_valid <= 1'b1;
            m_sof   <= (col == '0) && (row == '0);
            m_last  <= (col == COL_W'(IMG_W - 1));
            ax_q    <= ax;
            ay_q    <= ay;
            left2_q <= left1_q;
            left1_q <= kept;
        end else if (m_ready) begin
            m_valid <= 1'b0;
        end
    end

    assign m_x_int  = ax_q[ABS_W-1:FRAC_W];
    assign m_x_frac = ax_q[FRAC_W-1:0];
    assign m_y_int  = ay_q[ABS_W-1:FRAC_W];
    assign m_y_frac = ay_q[FRAC_W-1:0];
endmodule

// File: rtl/mapdec_chk.sv
module mapdec_chk #(
    parameter int IMG_W       = 1280,
    parameter int COORD_INT_W = 13,
    parameter int FRAC_W      = 7
) (
    input logic                   clk,
    input logic                   rst,
    input logic                   s_valid,
    input logic                   s_ready,
    input logic                   m_valid,
    input logic                   m_ready,
    input logic                   m_sof,
    input logic                   m_last,
    input logic [COORD_INT_W-1:0] m_x_int,
    input logic [FRAC_W-1:0]      m_x_frac,
    input logic [COORD_INT_W-1:0] m_y_int,
    input logic [FRAC_W-1:0]      m_y_frac
);
    localparam int CW = $clog2(IMG_W);
    logic [CW-1:0] out_col;

    // independent column count of delivered results
    always_ff @(posedge clk) begin
        if (rst) out_col <= '0;
        else if (m_valid && m_ready) begin
            if (m_sof)       out_col <= (IMG_W > 1) ? CW'(1) : '0;
            else if (m_last) out_col <= '0;
            else             out_col <= out_col + 1'b1;
        end
    end

    p_idle_after_reset_r1: assert property (@(posedge clk)
        rst |=> !m_valid);

    p_take_gives_result_r9: assert property (@(posedge clk) disable iff (rst)
        s_valid && s_ready |=> m_valid);

    p_stall_hold_r9: assert property (@(posedge clk) disable iff (rst)
        m_valid && !m_ready |=> m_valid && $stable(m_x_int) && $stable(m_x_frac)
            && $stable(m_y_int) && $stable(m_y_frac) && $stable(m_sof) && $stable(m_last));

    p_origin_whole_r6: assert property (@(posedge clk) disable iff (rst)
        m_valid && m_sof |-> (m_x_frac == '0) && (m_y_frac == '0));

    p_row_end_r8: assert property (@(posedge clk) disable iff (rst)
        m_valid && !m_sof |-> (m_last == (out_col == CW'(IMG_W - 1))));
endmodule

bind map_stream_decomp mapdec_chk #(
    .IMG_W(IMG_W), .COORD_INT_W(COORD_INT_W), .FRAC_W(7)
) u_chk (
    .clk(clk), .rst(rst), .s_valid(s_valid), .s_ready(s_ready),
    .m_valid(m_valid), .m_ready(m_ready), .m_sof(m_sof), .m_last(m_last),
    .m_x_int(m_x_int), .m_x_frac(m_x_frac), .m_y_int(m_y_int), .m_y_frac(m_y_frac)
);

// File: tb/map_stream_decomp_test.sv
module map_stream_decomp_test;
    localparam int W  = 12;
    localparam int H  = 5;
    localparam int CI = 13;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic s_valid = 1'b0, s_sof = 1'b0, m_ready = 1'b0;
    logic [7:0] s_data = '0;
    logic s_ready, m_valid, m_sof, m_last;
    logic [CI-1:0] m_x_int, m_y_int;
    logic [6:0] m_x_frac, m_y_frac;

    always #10 clk = ~clk;

    map_stream_decomp #(.IMG_W(W), .IMG_H(H), .COORD_INT_W(CI)) uut (
        .clk(clk), .rst(rst), .s_valid(s_valid), .s_ready(s_ready),
        .s_data(s_data), .s_sof(s_sof), .m_valid(m_valid), .m_ready(m_ready),
        .m_sof(m_sof), .m_last(m_last), .m_x_int(m_x_int), .m_x_frac(m_x_frac),
        .m_y_int(m_y_int), .m_y_frac(m_y_frac)
    );

    typedef struct {
        int xi; int xf; int yi; int yf;
        bit sof; bit last;
        string tx; string ty;
    } exp_t;

    exp_t q[$];
    int n_chk = 0, n_bad = 0;
    int rec [H][W];
    bit running = 0;

    task automatic check(bit ok, string tag, int act, int expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    function automatic int clamp8(int v);
        return (v > 127) ? 127 : ((v < -128) ? -128 : v);
    endfunction

    // model one beat from its code byte, push the expectation, then drive it
    task automatic beat(int m, int n, logic [7:0] b);
        exp_t e;
        int kept, miss, xo, yo, ax, ay;
        if (n < 2) kept = $signed(b) * 128;                 // R2
        else       kept = rec[m][n-2] + $signed(b);          // R3
        rec[m][n] = kept;
        if (m > 0 && n > 0) miss = (rec[m-1][n] + rec[m][n-1]) >>> 1;  // R5
        else if (n > 0)     miss = rec[m][n-1];              // R6
        else if (m > 0)     miss = rec[m-1][n];
        else                miss = 0;
        if (((m + n) % 2) == 0) begin xo = kept; yo = miss; end   // R4
        else                    begin xo = miss; yo = kept; end
        ax = n * 128 + xo;                                   // R7
        ay = m * 128 + yo;
        e.xi = ax >>> 7; e.xf = ax & 127;
        e.yi = ay >>> 7; e.yf = ay & 127;
        e.sof = (m == 0 && n == 0);
        e.last = (n == W - 1);
        e.tx = (((m + n) % 2) == 0) ? ((n < 2) ? "R2 R4 R7 x" : "R3 R4 R7 x")
                                    : ((m > 0 && n > 0) ? "R5 R7 x" : "R6 R7 x");
        e.ty = (((m + n) % 2) == 1) ? ((n < 2) ? "R2 R4 R7 y" : "R3 R4 R7 y")
                                    : ((m > 0 && n > 0) ? "R5 R7 y" : "R6 R7 y");
        q.push_back(e);
        @(negedge clk);
        s_valid = 1'b1; s_data = b; s_sof = e.sof;
        #1;
        while (!s_ready) begin @(negedge clk); #1; end
        @(posedge clk);
        #1 s_valid = 1'b0; s_sof = 1'b0;
    endtask

    // kind 0: compressed smooth field; 1: all +max codes; 2: all -min codes
    task automatic frame(int kind, int nbeats);
        int a0, bx, by, cx, cy, cnt, t, ref2;
        logic [7:0] b;
        a0 = ($urandom % 200) - 100;
        bx = ($urandom % 301) - 150; cx = ($urandom % 201) - 100;
        by = ($urandom % 201) - 100; cy = ($urandom % 301) - 150;
        cnt = 0;
        for (int m = 0; m < H; m++)
            for (int n = 0; n < W; n++) begin
                if (cnt < nbeats) begin
                    if (kind == 1) b = 8'h7F;
                    else if (kind == 2) b = 8'h80;
                    else begin
                        if (((m + n) % 2) == 0) t = a0 * 128 + bx * n + cx * m;
                        else                    t = -a0 * 64 + by * n + cy * m;
                        t = t + int'($urandom % 41) - 20;
                        if (n < 2) b = 8'(clamp8((t + 64) >>> 7));
                        else begin
                            ref2 = rec[m][n-2];
                            b = 8'(clamp8(t - ref2));
                        end
                    end
                    beat(m, n, b);
                end
                cnt++;
            end
    endtask

    // monitor / scoreboard with random back-pressure and stall checks
    initial begin : monitor
        bit stalled = 0;
        int sx, sy, sxf, syf;
        exp_t e;
        forever begin
            @(negedge clk);
            if (running) begin
                if (stalled) begin   // R9 output held during stall
                    check(m_valid == 1'b1, "R9 valid held", int'(m_valid), 1);
                    check(int'(m_x_int) == sx && int'(m_y_int) == sy &&
                          int'(m_x_frac) == sxf && int'(m_y_frac) == syf,
                          "R9 data held", int'(m_x_int), sx);
                end
                m_ready = (($urandom % 4) != 0);
                stalled = m_valid && !m_ready;
                if (stalled) begin
                    sx = int'(m_x_int); sy = int'(m_y_int);
                    sxf = int'(m_x_frac); syf = int'(m_y_frac);
                end
                if (m_valid && m_ready) begin
                    if (q.size() == 0) check(0, "R9 unexpected result", 1, 0);
                    else begin
                        e = q.pop_front();
                        check(int'($signed(m_x_int)) == e.xi, {e.tx, " int"}, int'($signed(m_x_int)), e.xi);
                        check(int'(m_x_frac) == e.xf, {e.tx, " frac"}, int'(m_x_frac), e.xf);
                        check(int'($signed(m_y_int)) == e.yi, {e.ty, " int"}, int'($signed(m_y_int)), e.yi);
                        check(int'(m_y_frac) == e.yf, {e.ty, " frac"}, int'(m_y_frac), e.yf);
                        check(m_sof == e.sof, "R8 sof", int'(m_sof), int'(e.sof));
                        check(m_last == e.last, "R8 last", int'(m_last), int'(e.last));
                    end
                end
            end
        end
    end

    initial begin : watchdog
        #(20 * 150000);
        check(0, "watchdog expired", 0, 1);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin : stimulus
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check(m_valid == 1'b0, "R1 m_valid after reset", int'(m_valid), 0);
        check(s_ready == 1'b1, "R1 s_ready after reset", int'(s_ready), 1);
        running = 1;
        frame(0, W * H);
        frame(1, W * H);             // R3 chain of +127 deltas
        frame(2, W * H);             // R3 chain of -128 deltas
        frame(0, 2 * W + 5);         // aborted frame
        frame(0, W * H);             // R8 restart by start-of-frame
        frame(0, W * H);
        for (int i = 0; i < 2000 && q.size() != 0; i++) @(negedge clk);
        check(q.size() == 0, "R9 all results delivered", q.size(), 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule